// File: doc/BRIEF.md
# Threaded-code return-stack sequencer

This block is a multi-cycle execution unit for a small group of extra processor instructions that speed up threaded-code interpreters. It keeps two pieces of interpreter state of its own: an index register that walks the current thread, and a return-stack pointer that addresses a second, software-visible stack in memory. Given an opcode, an operand and the processor's current PC, accumulator, index register X and the two width flags, it steps through the byte accesses the instruction needs. When it finishes it hands back the updated PC, accumulator, X, index register, return-stack pointer and negative/zero flags.

Memory is reached through a byte-wide request/ready port, one byte per accepted access. Words are stored with the low byte at the lower address. A push writes the high byte first at the current stack pointer and the low byte one address below it. Each instruction ends with a one-cycle commit, and `done` pulses once in that cycle. The surrounding core raises `start` for one cycle with the operands valid, waits for `done` and takes the results from the output ports.

Top module: `thread_seq`

## Requirements
- R1: After reset the index register reads `I_INIT` (0), the return-stack pointer reads `R_INIT` (0x01FF), N and Z read 0, and both `done` and `mem_req` are low.
- R2: Each memory access moves one byte and completes in a cycle where `mem_req` and `mem_ready` are both high. While `mem_ready` is low, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady.
- R3: Opcode 0x02 reads the low byte at I and the high byte at I+1, loads that word into PC, and adds 2 to I.
- R4: Opcode 0x22 pushes the current I onto the return stack (R decreases by 2), sets I to PC+2, and loads PC with the word read from PC and PC+1.
- R5: Opcode 0x42 loads the accumulator from I. When `acc_wide`=1 it reads two bytes, replaces all 16 bits and adds 2 to I. When `acc_wide`=0 it reads one byte, replaces bits 7:0, keeps bits 15:8 and adds 1 to I. N and Z are taken from the accumulator at that width.
- R6: A push writes bits 15:8 at address R and bits 7:0 at R-1, then subtracts 2 from R. Opcode 0x0B pushes I and opcode 0x44 pushes the 16-bit operand. Opcode 0x82 pushes PC plus the sign-extended operand bits 7:0 and leaves PC unchanged.
- R7: Opcode 0x54 reads a word from zero page, with the low byte at operand bits 7:0 and the high byte at the next address wrapped within page 0, and pushes that word.
- R8: Opcode 0x2B pulls I: it reads the low byte at R+1 and the high byte at R+2, loads I with that word and adds 2 to R.
- R9: Opcode 0x5C copies X to I, 0xDC copies I to X and 0xAB copies R to X, all 16 bits. N is bit 15 and Z tests 16 bits when `idx_narrow`=0. N is bit 7 and Z tests bits 7:0 when `idx_narrow`=1.
- R10: Opcode 0x8B copies all of X into R when `idx_narrow`=0. When `idx_narrow`=1 it replaces only R bits 7:0 with X bits 7:0.
- R11: `done` is high for exactly one cycle per accepted instruction, after its last memory access. A `start` raised while an instruction is in progress is ignored, and I and R do not change while no instruction is running.
- R12: An opcode outside the set above completes with no memory access. PC, A and X are returned as given, and I, R, N and Z are unchanged.
- R13: Instructions other than 0x42, 0x5C, 0xDC and 0xAB leave N and Z unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an instruction (taken only when idle) |
| opcode | input | 8 | Instruction code |
| operand | input | 16 | Immediate, relative offset or zero-page address |
| pc_in | input | 16 | Program counter at issue |
| a_in | input | 16 | Accumulator at issue |
| x_in | input | 16 | X register at issue |
| acc_wide | input | 1 | 1: 16-bit accumulator, 0: 8-bit |
| idx_narrow | input | 1 | 1: 8-bit index registers, 0: 16-bit |
| mem_req | output | 1 | Byte access requested |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid while `mem_ready` is high |
| mem_ready | input | 1 | Access accepted in this cycle |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | Resulting PC |
| a_out | output | 16 | Resulting accumulator |
| x_out | output | 16 | Resulting X |
| i_out | output | 16 | Index register |
| r_out | output | 16 | Return-stack pointer |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |

## Verification
The checker assumes that `mem_rdata` is valid in any cycle where `mem_ready` is high, and that the core leaves the unit alone between pulses of `start` apart from a stray `start`, which must be ignored. It tracks busy itself from `start` and `done`. The bench runs one instruction at a time and waits for `done` before the next. It uses a byte memory that answers every address below 0x400, so every pointer it sets up stays in that range. Its ready line is either always high or high one cycle in three, which exercises stalls. Only one instruction is ever deliberately disturbed by a second `start`.

// File: rtl/thread_seq_pkg.sv
// Shared constants and types for the threaded-code sequencer.
// Assumes a 16-bit address space reached one byte at a time.
package thread_seq_pkg;
    localparam int WORD_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int MAX_ACC = 4;
    localparam int STEP_W  = $clog2(MAX_ACC + 1);

    // Opcode values: the decode of the surrounding core depends on them.
    localparam logic [7:0] OP_NEXT    = 8'h02;
    localparam logic [7:0] OP_ENTER   = 8'h22;
    localparam logic [7:0] OP_NEXTA   = 8'h42;
    localparam logic [7:0] OP_PUSHREL = 8'h82;
    localparam logic [7:0] OP_PUSHIMM = 8'h44;
    localparam logic [7:0] OP_PUSHZP  = 8'h54;
    localparam logic [7:0] OP_PUSHI   = 8'h0B;
    localparam logic [7:0] OP_PULLI   = 8'h2B;
    localparam logic [7:0] OP_X2I     = 8'h5C;
    localparam logic [7:0] OP_I2X     = 8'hDC;
    localparam logic [7:0] OP_X2R     = 8'h8B;
    localparam logic [7:0] OP_R2X     = 8'hAB;

    typedef enum logic {ST_IDLE, ST_EXEC} seq_state_e;

    // One byte access of an instruction's micro-program.
    typedef struct packed {
        logic              act;
        logic              we;
        logic              hi;
        logic [WORD_W-1:0] addr;
        logic [BYTE_W-1:0] wdata;
    } uop_t;
endpackage

// File: rtl/thread_seq_nz.sv
// Negative/zero flag generator for a value at 8- or 16-bit width.
// Assumes W is a multiple of 8 and at least 16.
module thread_seq_nz #(
    parameter int W = 16
) (
    input  logic [W-1:0] val,
    input  logic         narrow,
    output logic         neg,
    output logic         zero
);
    localparam int LO_W = 8;

    // Pick the sign bit and zero test for the active width.
    always_comb begin
        if (narrow) begin
            neg  = val[LO_W-1];
            zero = (val[LO_W-1:0] == '0);
        end else begin
            neg  = val[W-1];
            zero = (val == '0);
        end
    end
endmodule

// File: rtl/thread_seq_uop.sv
// Micro-step decoder: for the latched opcode and current step it gives the
// byte access to perform and the number of accesses the opcode needs.
// Assumes inputs are stable for the whole instruction except tmp_q.
module thread_seq_uop
    import thread_seq_pkg::*;
(
    input  logic [7:0]        opc,
    input  logic [STEP_W-1:0] step,
    input  logic [WORD_W-1:0] i_q,
    input  logic [WORD_W-1:0] r_q,
    input  logic [WORD_W-1:0] pc_q,
    input  logic [WORD_W-1:0] opnd_q,
    input  logic [WORD_W-1:0] tmp_q,
    input  logic              acc_wide_q,
    output uop_t              uop,
    output logic [STEP_W-1:0] n_acc
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

    logic [WORD_W-1:0] push_val;
    logic [WORD_W-1:0] zp_lo;
    logic [WORD_W-1:0] zp_hi;
    uop_t              raw;

    function automatic uop_t rd(input logic [WORD_W-1:0] a, input logic h);
        rd = '{act: 1'b1, we: 1'b0, hi: h, addr: a, wdata: '0};
    endfunction

    function automatic uop_t wr(input logic [WORD_W-1:0] a, input logic [BYTE_W-1:0] d);
        wr = '{act: 1'b1, we: 1'b1, hi: 1'b0, addr: a, wdata: d};
    endfunction

    // Word an R-stack push stores, per opcode.
    always_comb begin
        zp_lo = {{(WORD_W-BYTE_W){1'b0}}, opnd_q[BYTE_W-1:0]};
        zp_hi = {{(WORD_W-BYTE_W){1'b0}}, opnd_q[BYTE_W-1:0] + 8'd1};
        unique case (opc)
            OP_PUSHREL: push_val = pc_q + {{(WORD_W-BYTE_W){opnd_q[BYTE_W-1]}}, opnd_q[BYTE_W-1:0]};
            OP_PUSHIMM: push_val = opnd_q;
            OP_PUSHZP:  push_val = tmp_q;
            default:    push_val = i_q;
        endcase
    end

    // Access list per opcode, indexed by step.
    always_comb begin
        raw   = '0;
        n_acc = '0;
        case (opc)
            OP_NEXT, OP_NEXTA: begin
                n_acc = (opc == OP_NEXTA && !acc_wide_q) ? STEP_W'(1) : STEP_W'(2);
                raw   = (step == 0) ? rd(i_q, 1'b0) : rd(i_q + ONE, 1'b1);
            end
            OP_ENTER: begin
                n_acc = STEP_W'(4);
                case (step)
                    STEP_W'(0): raw = wr(r_q, push_val[WORD_W-1:BYTE_W]);
                    STEP_W'(1): raw = wr(r_q - ONE, push_val[BYTE_W-1:0]);
                    STEP_W'(2): raw = rd(pc_q, 1'b0);
                    default:    raw = rd(pc_q + ONE, 1'b1);
                endcase
            end
            OP_PUSHREL, OP_PUSHIMM, OP_PUSHI: begin
                n_acc = STEP_W'(2);
                raw   = (step == 0) ? wr(r_q, push_val[WORD_W-1:BYTE_W])
                                    : wr(r_q - ONE, push_val[BYTE_W-1:0]);
            end
            OP_PUSHZP: begin
                n_acc = STEP_W'(4);
                case (step)
                    STEP_W'(0): raw = rd(zp_lo, 1'b0);
                    STEP_W'(1): raw = rd(zp_hi, 1'b1);
                    STEP_W'(2): raw = wr(r_q, push_val[WORD_W-1:BYTE_W]);
                    default:    raw = wr(r_q - ONE, push_val[BYTE_W-1:0]);
                endcase
            end
            OP_PULLI: begin
                n_acc = STEP_W'(2);
                raw   = (step == 0) ? rd(r_q + ONE, 1'b0) : rd(r_q + TWO, 1'b1);
            end
            default: begin
                n_acc = '0;
                raw   = '0;
            end
        endcase
    end

    // Gate the access with the step count.
    always_comb begin
        uop     = raw;
        uop.act = (step < n_acc);
    end
endmodule

// File: rtl/thread_seq.sv
// Threaded-code return-stack sequencer top. Holds the index register and
// return-stack pointer, runs one instruction at a time through the byte
// port, then commits all results in one cycle and pulses done.
// Assumes mem_rdata is valid whenever mem_ready is high.
module thread_seq
    import thread_seq_pkg::*;
#(
    parameter logic [WORD_W-1:0] I_INIT = '0,
    parameter logic [WORD_W-1:0] R_INIT = 16'h01FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [7:0]        opcode,
    input  logic [WORD_W-1:0] operand,
    input  logic [WORD_W-1:0] pc_in,
    input  logic [WORD_W-1:0] a_in,
    input  logic [WORD_W-1:0] x_in,
    input  logic              acc_wide,
    input  logic              idx_narrow,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic              done,
    output logic [WORD_W-1:0] pc_out,
    output logic [WORD_W-1:0] a_out,
    output logic [WORD_W-1:0] x_out,
    output logic [WORD_W-1:0] i_out,
    output logic [WORD_W-1:0] r_out,
    output logic              n_out,
    output logic              z_out
);
    localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
    localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

    seq_state_e        state;
    logic [STEP_W-1:0] step;
    logic [7:0]        opc_q;
    logic [WORD_W-1:0] opnd_q, pc_q, a_q, x_q, i_q, r_q, tmp_q;
    logic              acc_wide_q, idx_narrow_q;
    logic              n_q, z_q, done_q;

    uop_t              uop;
    logic [STEP_W-1:0] n_acc;

    logic [WORD_W-1:0] pc_c, a_c, x_c, i_c, r_c, nz_val;
    logic              nz_upd, nz_nar, nz_n, nz_z;

    thread_seq_uop u_uop (
        .opc        (opc_q),
        .step       (step),
        .i_q        (i_q),
        .r_q        (r_q),
        .pc_q       (pc_q),
        .opnd_q     (opnd_q),
        .tmp_q      (tmp_q),
        .acc_wide_q (acc_wide_q),
        .uop        (uop),
        .n_acc      (n_acc)
    );

    thread_seq_nz #(.W(WORD_W)) u_nz (
        .val    (nz_val),
        .narrow (nz_nar),
        .neg    (nz_n),
        .zero   (nz_z)
    );

    // Results written back in the commit cycle.
    always_comb begin
        pc_c   = pc_q;
        a_c    = a_q;
        x_c    = x_q;
        i_c    = i_q;
        r_c    = r_q;
        nz_upd = 1'b0;
        nz_val = '0;
        nz_nar = idx_narrow_q;
        case (opc_q)
            OP_NEXT: begin
                pc_c = tmp_q;
                i_c  = i_q + TWO;
            end
            OP_ENTER: begin
                pc_c = tmp_q;
                i_c  = pc_q + TWO;
                r_c  = r_q - TWO;
            end
            OP_NEXTA: begin
                a_c    = acc_wide_q ? tmp_q : {a_q[WORD_W-1:BYTE_W], tmp_q[BYTE_W-1:0]};
                i_c    = i_q + (acc_wide_q ? TWO : ONE);
                nz_upd = 1'b1;
                nz_val = a_c;
                nz_nar = !acc_wide_q;
            end
            OP_PUSHREL, OP_PUSHIMM, OP_PUSHZP, OP_PUSHI: r_c = r_q - TWO;
            OP_PULLI: begin
                i_c = tmp_q;
                r_c = r_q + TWO;
            end
            OP_X2I: begin
                i_c    = x_q;
                nz_upd = 1'b1;
                nz_val = x_q;
            end
            OP_I2X: begin
                x_c    = i_q;
                nz_upd = 1'b1;
                nz_val = i_q;
            end
            OP_X2R: r_c = idx_narrow_q ? {r_q[WORD_W-1:BYTE_W], x_q[BYTE_W-1:0]} : x_q;
            OP_R2X: begin
                x_c    = r_q;
                nz_upd = 1'b1;
                nz_val = r_q;
            end
            default: ;
        endcase
    end

    // Sequencer: accept, step through byte accesses, commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= ST_IDLE;
            step         <= '0;
            opc_q        <= '0;
            opnd_q       <= '0;
            pc_q         <= '0;
            a_q          <= '0;
            x_q          <= '0;
            i_q          <= I_INIT;
            r_q          <= R_INIT;
            tmp_q        <= '0;
            acc_wide_q   <= 1'b0;
            idx_narrow_q <= 1'b0;
            n_q          <= 1'b0;
            z_q          <= 1'b0;
            done_q       <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        opc_q        <= opcode;
                        opnd_q       <= operand;
                        pc_q         <= pc_in;
                        a_q          <= a_in;
                        x_q          <= x_in;
                        acc_wide_q   <= acc_wide;
                        idx_narrow_q <= idx_narrow;
                        step         <= '0;
                        state        <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    if (uop.act) begin
                        if (mem_ready) begin
                            if (!uop.we) begin
                                if (uop.hi) tmp_q[WORD_W-1:BYTE_W] <= mem_rdata;
                                else        tmp_q[BYTE_W-1:0]      <= mem_rdata;
                            end
                            step <= step + STEP_W'(1);
                        end
                    end else begin
                        pc_q   <= pc_c;
                        a_q    <= a_c;
                        x_q    <= x_c;
                        i_q    <= i_c;
                        r_q    <= r_c;
                        if (nz_upd) begin
                            n_q <= nz_n;
                            z_q <= nz_z;
                        end
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign mem_req   = (state == ST_EXEC) && uop.act;
    assign mem_we    = uop.we;
    assign mem_addr  = uop.addr;
    assign mem_wdata = uop.wdata;
    assign done      = done_q;
    assign pc_out    = pc_q;
    assign a_out     = a_q;
    assign x_out     = x_q;
    assign i_out     = i_q;
    assign r_out     = r_q;
    assign n_out     = n_q;
    assign z_out     = z_q;
endmodule

// File: rtl/thread_seq_chk.sv
// Protocol checker for thread_seq, attached with bind. Tracks whether an
// instruction is outstanding from start/done alone.
module thread_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        mem_req,
    input logic        mem_we,
    input logic [15:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ready,
    input logic        done,
    input logic [15:0] i_out,
    input logic [15:0] r_out
);
    logic busy_c;

    // Outstanding-instruction tracker from the port handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)                         busy_c <= 1'b0;
        else if (start && (!busy_c || done)) busy_c <= 1'b1;
        else if (done)                      busy_c <= 1'b0;
    end

    // R2: a stalled request keeps its attributes
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata)));

    // R2: no access in the completion cycle and none while idle
    p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (busy_c && !done));

    // R11: done is a single-cycle pulse
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11: done only for an accepted instruction
    p_done_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_c);

    // R11: I and R hold while nothing runs
    p_idle_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((!busy_c || done) && !start) |=> ($stable(i_out) && $stable(r_out)));
endmodule

bind thread_seq thread_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready),
    .done      (done),
    .i_out     (i_out),
    .r_out     (r_out)
);

// File: tb/thread_seq_bench.sv
`timescale 1ns/1ps
module thread_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic [15:0] operand = '0, pc_in = '0, a_in = '0, x_in = '0;
    logic        acc_wide = 1'b0, idx_narrow = 1'b0;
    logic        mem_req, mem_we, mem_ready = 1'b1, done;
    logic [15:0] mem_addr, pc_out, a_out, x_out, i_out, r_out;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        n_out, z_out;

    int errors = 0;
    int checks = 0;
    bit stall_mode = 1'b0;
    int cyc = 0;

    logic [7:0]  mem [0:1023];
    logic        poke_en = 1'b0;
    logic [9:0]  poke_addr = '0;
    logic [7:0]  poke_data = '0;

    typedef struct packed {
        logic [15:0] pc, a, x, i, r;
        logic        n, z;
    } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    thread_seq u_thread_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .operand(operand),
        .pc_in(pc_in), .a_in(a_in), .x_in(x_in), .acc_wide(acc_wide), .idx_narrow(idx_narrow),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .done(done), .pc_out(pc_out),
        .a_out(a_out), .x_out(x_out), .i_out(i_out), .r_out(r_out), .n_out(n_out), .z_out(z_out)
    );

    // Byte memory model: reads combinational, writes on accepted cycles.
    assign mem_rdata = mem[mem_addr[9:0]];
    always @(posedge clk) begin
        if (poke_en) mem[poke_addr] <= poke_data;
        else if (mem_req && mem_ready && mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    end

    // Ready pattern: always ready, or one cycle in three.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        mem_ready <= !stall_mode || (cyc % 3 == 2);
    end

    task automatic chk(input logic [15:0] got, input logic [15:0] exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // Monitor: pop the expected result at each done and compare.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                chk(16'h0001, 16'h0000, "R11 unexpected done");
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(pc_out, e.pc, {t, " pc"});
                chk(a_out, e.a, {t, " a"});
                chk(x_out, e.x, {t, " x"});
                chk(i_out, e.i, {t, " i"});
                chk(r_out, e.r, {t, " r"});
                chk({15'd0, n_out}, {15'd0, e.n}, {t, " n"});
                chk({15'd0, z_out}, {15'd0, e.z}, {t, " z"});
            end
        end
    end

    task automatic poke(input logic [9:0] a, input logic [7:0] d);
        @(negedge clk);
        poke_en = 1'b1; poke_addr = a; poke_data = d;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic peek(input logic [9:0] a, input logic [7:0] d, input string what);
        chk({8'h00, mem[a]}, {8'h00, d}, what);
    endtask

    // Driver: queue the expectation, issue, wait for completion.
    task automatic issue(input logic [7:0] op, input logic [15:0] opnd, input logic [15:0] pc,
                         input logic [15:0] a, input logic [15:0] x, input logic wide, input logic nar,
                         input logic [15:0] e_pc, input logic [15:0] e_a, input logic [15:0] e_x,
                         input logic [15:0] e_i, input logic [15:0] e_r, input logic e_n, input logic e_z,
                         input string tag, input bit meddle);
        exp_t e;
        e = '{pc: e_pc, a: e_a, x: e_x, i: e_i, r: e_r, n: e_n, z: e_z};
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        opcode = op; operand = opnd; pc_in = pc; a_in = a; x_in = x;
        acc_wide = wide; idx_narrow = nar; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (meddle) begin
            @(negedge clk);
            opcode = 8'h8B; x_in = 16'h0000; idx_narrow = 1'b0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(i_out, 16'h0000, "R1 i after reset");
        chk(r_out, 16'h01FF, "R1 r after reset");
        chk({14'd0, n_out, z_out}, 16'h0000, "R1 flags after reset");
        chk({14'd0, done, mem_req}, 16'h0000, "R1 done/req after reset");

        poke(10'h120, 8'h34); poke(10'h121, 8'h02);
        poke(10'h0FF, 8'h11); poke(10'h000, 8'h22); poke(10'h100, 8'h99);
        poke(10'h340, 8'h78); poke(10'h341, 8'h03);
        poke(10'h342, 8'h00); poke(10'h343, 8'h80); poke(10'h344, 8'h00);

        // R9 X to I, 16-bit
        issue(8'h5C, 0, 16'h0100, 16'h1111, 16'h0120, 1, 0, 16'h0100, 16'h1111, 16'h0120, 16'h0120, 16'h01FF, 0, 0, "R9 x2i wide", 0);
        // R3 next word, R13 flags kept
        issue(8'h02, 0, 16'h0101, 16'h1111, 16'h2222, 1, 0, 16'h0234, 16'h1111, 16'h2222, 16'h0122, 16'h01FF, 0, 0, "R3 next", 0);
        // R9 I to X
        issue(8'hDC, 0, 16'h0102, 16'h1111, 16'hFFFF, 1, 0, 16'h0102, 16'h1111, 16'h0122, 16'h0122, 16'h01FF, 0, 0, "R9 i2x", 0);
        // R9 zero at 16 bits
        issue(8'h5C, 0, 16'h0103, 16'h1111, 16'h0000, 1, 0, 16'h0103, 16'h1111, 16'h0000, 16'h0000, 16'h01FF, 0, 1, "R9 x2i zero", 0);
        // R9 zero at 8 bits with nonzero high byte
        issue(8'h5C, 0, 16'h0104, 16'h1111, 16'h0100, 1, 1, 16'h0104, 16'h1111, 16'h0100, 16'h0100, 16'h01FF, 0, 1, "R9 x2i narrow zero", 0);
        // R6 push I, R13 flags kept
        issue(8'h0B, 0, 16'h0105, 16'h1111, 16'h2222, 1, 0, 16'h0105, 16'h1111, 16'h2222, 16'h0100, 16'h01FD, 0, 1, "R6 push i", 0);
        peek(10'h1FF, 8'h01, "R6 push i high byte");
        peek(10'h1FE, 8'h00, "R6 push i low byte");
        // R6 push immediate
        issue(8'h44, 16'hBEEF, 16'h0106, 16'h1111, 16'h2222, 1, 0, 16'h0106, 16'h1111, 16'h2222, 16'h0100, 16'h01FB, 0, 1, "R6 push imm", 0);
        peek(10'h1FD, 8'hBE, "R6 push imm high");
        peek(10'h1FC, 8'hEF, "R6 push imm low");
        // R6 relative push, negative and positive offsets
        issue(8'h82, 16'h0080, 16'h0300, 16'h1111, 16'h2222, 1, 0, 16'h0300, 16'h1111, 16'h2222, 16'h0100, 16'h01F9, 0, 1, "R6 push rel neg", 0);
        peek(10'h1FB, 8'h02, "R6 rel neg high");
        peek(10'h1FA, 8'h80, "R6 rel neg low");
        issue(8'h82, 16'h007F, 16'h03F0, 16'h1111, 16'h2222, 1, 0, 16'h03F0, 16'h1111, 16'h2222, 16'h0100, 16'h01F7, 0, 1, "R6 push rel pos", 0);
        peek(10'h1F9, 8'h04, "R6 rel pos high");
        peek(10'h1F8, 8'h6F, "R6 rel pos low");
        // R7 zero-page indirect with page wrap
        issue(8'h54, 16'h00FF, 16'h0107, 16'h1111, 16'h2222, 1, 0, 16'h0107, 16'h1111, 16'h2222, 16'h0100, 16'h01F5, 0, 1, "R7 push zp", 0);
        peek(10'h1F7, 8'h22, "R7 zp wrap high");
        peek(10'h1F6, 8'h11, "R7 zp low");
        // R8 pull I
        issue(8'h2B, 0, 16'h0108, 16'h1111, 16'h2222, 1, 0, 16'h0108, 16'h1111, 16'h2222, 16'h2211, 16'h01F7, 0, 1, "R8 pull i", 0);
        // R4 enter word
        issue(8'h22, 0, 16'h0340, 16'h1111, 16'h2222, 1, 0, 16'h0378, 16'h1111, 16'h2222, 16'h0342, 16'h01F5, 0, 1, "R4 enter", 0);
        peek(10'h1F7, 8'h22, "R4 enter pushed high");
        peek(10'h1F6, 8'h11, "R4 enter pushed low");
        // R5 accumulator load, both widths
        issue(8'h42, 0, 16'h0109, 16'h1234, 16'h2222, 1, 0, 16'h0109, 16'h8000, 16'h2222, 16'h0344, 16'h01F5, 1, 0, "R5 nexta wide", 0);
        issue(8'h42, 0, 16'h010A, 16'h5A5A, 16'h2222, 0, 0, 16'h010A, 16'h5A00, 16'h2222, 16'h0345, 16'h01F5, 0, 1, "R5 nexta narrow", 0);
        // R9 R to X at both widths
        issue(8'hAB, 0, 16'h010B, 16'h1111, 16'h0000, 1, 0, 16'h010B, 16'h1111, 16'h01F5, 16'h0345, 16'h01F5, 0, 0, "R9 r2x wide", 0);
        issue(8'hAB, 0, 16'h010C, 16'h1111, 16'h0000, 1, 1, 16'h010C, 16'h1111, 16'h01F5, 16'h0345, 16'h01F5, 1, 0, "R9 r2x narrow", 0);
        // R10 X to R at both widths, R13 flags kept
        issue(8'h8B, 0, 16'h010D, 16'h1111, 16'h01E0, 1, 0, 16'h010D, 16'h1111, 16'h01E0, 16'h0345, 16'h01E0, 1, 0, "R10 x2r wide", 0);
        issue(8'h8B, 0, 16'h010E, 16'h1111, 16'hAB33, 1, 1, 16'h010E, 16'h1111, 16'hAB33, 16'h0345, 16'h0133, 1, 0, "R10 x2r narrow", 0);
        // R12 unknown opcode
        issue(8'hEA, 16'h1234, 16'h010F, 16'h4444, 16'h5555, 1, 0, 16'h010F, 16'h4444, 16'h5555, 16'h0345, 16'h0133, 1, 0, "R12 unknown", 0);
        chk({15'd0, mem_req}, 16'h0000, "R12 no access");

        // R2 stalled port
        stall_mode = 1'b1;
        issue(8'h8B, 0, 16'h0110, 16'h1111, 16'h01F0, 1, 0, 16'h0110, 16'h1111, 16'h01F0, 16'h0345, 16'h01F0, 1, 0, "R2 x2r stalled", 0);
        // R11 start during a push is ignored
        issue(8'h0B, 0, 16'h0111, 16'h1111, 16'h2222, 1, 0, 16'h0111, 16'h1111, 16'h2222, 16'h0345, 16'h01EE, 1, 0, "R11 push with stray start", 1);
        peek(10'h1F0, 8'h03, "R2 stalled push high");
        peek(10'h1EF, 8'h45, "R2 stalled push low");
        issue(8'h5C, 0, 16'h0112, 16'h1111, 16'h0120, 1, 0, 16'h0112, 16'h1111, 16'h0120, 16'h0120, 16'h01EE, 0, 0, "R2 x2i stalled", 0);
        issue(8'h02, 0, 16'h0113, 16'h1111, 16'h0120, 1, 0, 16'h0234, 16'h1111, 16'h0120, 16'h0122, 16'h01EE, 0, 0, "R2 next stalled", 0);
        stall_mode = 1'b0;

        repeat (5) @(negedge clk);
        chk(16'(exp_q.size()), 16'h0000, "R11 every instruction completed once");
        finish_run();
    end
endmodule